// File: doc/BRIEF.md
# NOR Flash Program and Sector-Erase Sequencer

This block turns a single host request into the bus cycles that a 16-bit parallel NOR flash with an unlock-style command set needs for word programming or for erasing a range of sectors. The host raises a request level with an operation code and its operands. The engine takes it when idle and works through the unlock chain one write per clock. It then polls bit 7 of the target location until the part reports completion or a poll budget runs out. It finishes with a one-cycle done pulse that carries a status code and a count of skipped sectors.

A bitmap input, one bit per sector, marks sectors as write-protected. A program aimed at a protected sector is refused without touching the bus. An erase range steps over protected sectors in ascending order and counts them. After each sector erase attempt the engine writes the read-mode reset command to the sector base. After a program timeout it writes the same command to the target word. A sector is `2**SECT_SHIFT` words and the sector index is the upper `ADDR_W-SECT_SHIFT` address bits. The unlock offsets need `ADDR_W` of at least 11, and `ERASE_WAIT` must be at least 1.

The state machine has ten states:
- IDLE: waits for a request.
- CHECK: validates the operands.
- SECT: looks up protection for the current erase sector.
- CMD: issues one command write per cycle.
- WAIT: holds off before erase polling.
- PRD: issues a poll read.
- PCHK: evaluates the poll data.
- RST: writes the read-mode reset.
- NEXT: advances or ends the erase range.
- DONE: pulses the result.

The transitions are:
- IDLE to CHECK on acceptance.
- CHECK to DONE (refused), to CMD (program) or to SECT (erase).
- SECT to NEXT (protected) or to CMD.
- CMD to CMD until the final write, then to PRD (program) or to WAIT (erase).
- WAIT to PRD once the delay has elapsed.
- PRD to PCHK.
- PCHK to PRD (retry), to DONE (program complete) or to RST (erase finished, or budget exhausted).
- RST to DONE (program timeout or erase failure) or to NEXT.
- NEXT to SECT (more sectors) or to DONE.
- DONE to IDLE.

Top module: `nfc_engine`

## Requirements
- R1: `ack` is high exactly in a cycle where the engine is idle and `req` is high; from acceptance until the cycle after `done` it stays low even with `req` held high, and operands changed after acceptance have no effect.
- R2: A program issues exactly four single-cycle writes: 0x00AA at word 0x555, 0x0055 at 0x2AA, 0x00A0 at 0x555, then the data word at the target address.
- R3: Program completes with status 0 when bit 7 read from the target equals bit 7 of the data word; no further write follows.
- R4: After `PROG_POLLS` poll reads that all miss, the engine writes 0x00F0 to the target and reports status 1; a match on the last permitted read counts as success.
- R5: A program whose target sector has its `wp_map` bit set reports status 3 and makes no flash read or write.
- R6: Each unprotected erase sector gets six writes: 0x00AA@0x555, 0x0055@0x2AA, 0x0080@0x555, 0x00AA@0x555, 0x0055@0x2AA, then 0x0030 at the sector base (sector index shifted left by `SECT_SHIFT`).
- R7: The first poll read of a sector erase occurs exactly `ERASE_WAIT+1` cycles after the 0x0030 write; the sector erase completes when bit 7 reads 1.
- R8: After every sector erase attempt, successful or not, 0x00F0 is written to the sector base.
- R9: An erase whose first sector is negative (two's complement `first_sect`) or greater than `last_sect` reports status 2 with no flash cycles.
- R10: Erase visits sectors first to last in ascending order; protected sectors get no cycles and are counted in `skip_cnt` (zero for a program).
- R11: If a sector's poll budget of `ERASE_POLLS` reads runs out, the range stops after that sector's reset write with status 1, and later sectors are not touched.
- R12: After reset, `done`, `ack` (with `req` low), `f_we` and `f_rd` are low. `done` is a single-cycle pulse. `f_we` and `f_rd` are never high together, and poll data is taken from `f_rdata` one cycle after `f_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request level from host |
| ack | output | 1 | Request taken this cycle |
| op | input | 1 | 0 = word program, 1 = sector-range erase |
| addr | input | ADDR_W | Program target word address |
| wdata | input | 16 | Program data word |
| first_sect | input | SN_W+1 | First erase sector, signed |
| last_sect | input | SN_W | Last erase sector |
| wp_map | input | 2**SN_W | Write-protect bit per sector |
| done | output | 1 | Operation finished (one cycle) |
| status | output | 2 | 0 ok, 1 timeout, 2 bad range, 3 protected |
| skip_cnt | output | SN_W+1 | Protected sectors skipped |
| f_addr | output | ADDR_W | Flash word address |
| f_wdata | output | 16 | Flash write data |
| f_we | output | 1 | Flash write strobe |
| f_rd | output | 1 | Flash read strobe |
| f_rdata | input | 16 | Flash read data, valid the cycle after `f_rd` |

## Verification
Two functions can coincide in one poll-check cycle: the completion match and the exhaustion of the poll budget. The flash model in the bench can be told to stay busy for exactly one read fewer than the budget, so the last permitted read is the first that reports ready. This is done for both program and erase, with the budget itself as the neighbouring case. The result is judged by the status code and by whether a reset write appears in the logged cycle list. Completion must win: status 0 and no reset for a program, and the erase range carrying on to the next sector.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SECT,
        ST_CMD,
        ST_WAIT,
        ST_PRD,
        ST_PCHK,
        ST_RST,
        ST_NEXT,
        ST_DONE
    } nfc_state_e;

    typedef enum logic [1:0] {
        STS_OK      = 2'd0,
        STS_TIMEOUT = 2'd1,
        STS_RANGE   = 2'd2,
        STS_PROT    = 2'd3
    } nfc_sts_e;

    // one command bus cycle
    typedef struct packed {
        logic       to_target;  // address is the operation target, not an unlock offset
        logic       at_hi;      // unlock offset 0x555 (else 0x2AA)
        logic [7:0] code;
        logic       last;
    } nfc_cyc_t;

    localparam logic [7:0]  CODE_KEY1  = 8'hAA;
    localparam logic [7:0]  CODE_KEY2  = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
    localparam logic [7:0]  CODE_READ  = 8'hF0;
    localparam logic [10:0] OFS_HI     = 11'h555;
    localparam logic [10:0] OFS_LO     = 11'h2AA;

endpackage

// File: rtl/nfc_cmd_rom.sv
module nfc_cmd_rom
    import nfc_pkg::*;
(
    input  logic       is_erase,
    input  logic [2:0] step,
    output nfc_cyc_t   cyc
);

    function automatic nfc_cyc_t mk(input logic tgt, input logic hi,
                                    input logic [7:0] c, input logic lst);
        nfc_cyc_t r;
        r.to_target = tgt;
        r.at_hi     = hi;
        r.code      = c;
        r.last      = lst;
        return r;
    endfunction

    always_comb begin
        if (!is_erase) begin
            case (step)
                3'd0:    cyc = mk(1'b0, 1'b1, CODE_KEY1, 1'b0);
                3'd1:    cyc = mk(1'b0, 1'b0, CODE_KEY2, 1'b0);
                3'd2:    cyc = mk(1'b0, 1'b1, CODE_PROG, 1'b0);
                default: cyc = mk(1'b1, 1'b0, 8'h00,     1'b1);
            endcase
        end else begin
            case (step)
                3'd0:    cyc = mk(1'b0, 1'b1, CODE_KEY1,  1'b0);
                3'd1:    cyc = mk(1'b0, 1'b0, CODE_KEY2,  1'b0);
                3'd2:    cyc = mk(1'b0, 1'b1, CODE_ERASE, 1'b0);
                3'd3:    cyc = mk(1'b0, 1'b1, CODE_KEY1,  1'b0);
                3'd4:    cyc = mk(1'b0, 1'b0, CODE_KEY2,  1'b0);
                default: cyc = mk(1'b1, 1'b0, CODE_SECT,  1'b1);
            endcase
        end
    end

endmodule

// File: rtl/nfc_tick.sv
module nfc_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/nfc_range.sv
module nfc_range #(
    parameter int SN_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic signed [SN_W:0]   first_in,
    input  logic [SN_W-1:0]        last_in,
    input  logic                   advance,
    input  logic                   skip,
    output logic [SN_W-1:0]        cur,
    output logic                   at_last,
    output logic                   bad,
    output logic [SN_W:0]          skip_cnt
);

    logic [SN_W:0]   first_q;
    logic [SN_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            last_q   <= '0;
            cur      <= '0;
            skip_cnt <= '0;
        end else if (load) begin
            first_q  <= first_in;
            last_q   <= last_in;
            cur      <= first_in[SN_W-1:0];
            skip_cnt <= '0;
        end else begin
            if (advance) cur <= cur + SN_W'(1);
            if (skip)    skip_cnt <= skip_cnt + (SN_W+1)'(1);
        end
    end

    assign bad     = first_q[SN_W] || (first_q[SN_W-1:0] > last_q);
    assign at_last = (cur == last_q);

endmodule

// File: rtl/nfc_engine.sv
module nfc_engine
    import nfc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SECT_SHIFT  = 12,
    parameter int ERASE_WAIT  = 100000,
    parameter int PROG_POLLS  = 1024,
    parameter int ERASE_POLLS = 1048576,
    localparam int SN_W       = ADDR_W - SECT_SHIFT,
    localparam int N_SECT     = 1 << SN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    output logic                 ack,
    input  logic                 op,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wdata,
    input  logic signed [SN_W:0] first_sect,
    input  logic [SN_W-1:0]      last_sect,
    input  logic [N_SECT-1:0]    wp_map,
    output logic                 done,
    output logic [1:0]           status,
    output logic [SN_W:0]        skip_cnt,
    output logic [ADDR_W-1:0]    f_addr,
    output logic [15:0]          f_wdata,
    output logic                 f_we,
    output logic                 f_rd,
    input  logic [15:0]          f_rdata
);

    localparam int CNT_MAX0 = (ERASE_WAIT > PROG_POLLS) ? ERASE_WAIT : PROG_POLLS;
    localparam int CNT_MAX  = (CNT_MAX0 > ERASE_POLLS) ? CNT_MAX0 : ERASE_POLLS;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(ERASE_WAIT - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_POLLS - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_POLLS - 1);

    nfc_state_e state_q, state_d;

    logic              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       data_q;
    logic [2:0]        step_q;
    nfc_sts_e          sts_q;
    logic              fail_q;

    logic accept;
    logic cnt_clr, cnt_inc, step_clr, step_inc;
    logic rng_adv, rng_skip, sts_set, fail_set;
    nfc_sts_e sts_val;

    logic [CNT_W-1:0]  cnt;
    logic [SN_W-1:0]   cur;
    logic              at_last, rng_bad;
    nfc_cyc_t          cyc;
    logic [ADDR_W-1:0] tgt_addr;
    logic              poll_ok, poll_last;
    logic              unused_rdata;

    nfc_cmd_rom u_rom (
        .is_erase (op_q),
        .step     (step_q),
        .cyc      (cyc)
    );

    nfc_tick #(.W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    nfc_range #(.SN_W(SN_W)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .first_in (first_sect),
        .last_in  (last_sect),
        .advance  (rng_adv),
        .skip     (rng_skip),
        .cur      (cur),
        .at_last  (at_last),
        .bad      (rng_bad),
        .skip_cnt (skip_cnt)
    );

    assign accept       = (state_q == ST_IDLE) && req;
    assign tgt_addr     = op_q ? {cur, {SECT_SHIFT{1'b0}}} : addr_q;
    assign poll_ok      = op_q ? f_rdata[7] : (f_rdata[7] == data_q[7]);
    assign poll_last    = op_q ? (cnt == ERASE_LAST) : (cnt == PROG_LAST);
    assign unused_rdata = ^{f_rdata[15:8], f_rdata[6:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and internal strobes
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        step_clr = 1'b0;
        step_inc = 1'b0;
        rng_adv  = 1'b0;
        rng_skip = 1'b0;
        sts_set  = 1'b0;
        sts_val  = STS_OK;
        fail_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_CHECK;
            ST_CHECK: begin
                step_clr = 1'b1;
                if (!op_q) begin
                    if (wp_map[addr_q[ADDR_W-1:SECT_SHIFT]]) begin
                        sts_set = 1'b1; sts_val = STS_PROT; state_d = ST_DONE;
                    end else begin
                        state_d = ST_CMD;
                    end
                end else if (rng_bad) begin
                    sts_set = 1'b1; sts_val = STS_RANGE; state_d = ST_DONE;
                end else begin
                    state_d = ST_SECT;
                end
            end
            ST_SECT: begin
                step_clr = 1'b1;
                if (wp_map[cur]) begin
                    rng_skip = 1'b1; state_d = ST_NEXT;
                end else begin
                    state_d = ST_CMD;
                end
            end
            ST_CMD: begin
                if (cyc.last) begin
                    cnt_clr = 1'b1;
                    state_d = op_q ? ST_WAIT : ST_PRD;
                end else begin
                    step_inc = 1'b1;
                end
            end
            ST_WAIT: begin
                if (cnt == WAIT_LAST) begin
                    cnt_clr = 1'b1; state_d = ST_PRD;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_PRD: state_d = ST_PCHK;
            ST_PCHK: begin
                if (poll_ok) begin
                    if (op_q) begin
                        state_d = ST_RST;
                    end else begin
                        sts_set = 1'b1; sts_val = STS_OK; state_d = ST_DONE;
                    end
                end else if (poll_last) begin
                    fail_set = 1'b1; state_d = ST_RST;
                end else begin
                    cnt_inc = 1'b1; state_d = ST_PRD;
                end
            end
            ST_RST: begin
                if (!op_q || fail_q) begin
                    sts_set = 1'b1; sts_val = STS_TIMEOUT; state_d = ST_DONE;
                end else begin
                    state_d = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (at_last) begin
                    sts_set = 1'b1; sts_val = STS_OK; state_d = ST_DONE;
                end else begin
                    rng_adv = 1'b1; state_d = ST_SECT;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
            sts_q  <= STS_OK;
            fail_q <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= op;
                addr_q <= addr;
                data_q <= wdata;
                fail_q <= 1'b0;
            end else if (fail_set) begin
                fail_q <= 1'b1;
            end
            if (step_clr)      step_q <= '0;
            else if (step_inc) step_q <= step_q + 3'd1;
            if (sts_set) sts_q <= sts_val;
        end
    end

    // outputs
    always_comb begin
        ack     = accept;
        done    = (state_q == ST_DONE);
        status  = sts_q;
        f_we    = 1'b0;
        f_rd    = 1'b0;
        f_addr  = '0;
        f_wdata = '0;
        unique case (state_q)
            ST_CMD: begin
                f_we = 1'b1;
                if (cyc.to_target) f_addr = tgt_addr;
                else               f_addr = ADDR_W'(cyc.at_hi ? OFS_HI : OFS_LO);
                f_wdata = (cyc.to_target && !op_q) ? data_q : {8'h00, cyc.code};
            end
            ST_RST: begin
                f_we    = 1'b1;
                f_addr  = tgt_addr;
                f_wdata = {8'h00, CODE_READ};
            end
            ST_PRD: begin
                f_rd   = 1'b1;
                f_addr = tgt_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nfc_engine_chk.sv
module nfc_engine_chk #(
    parameter int ADDR_W     = 16,
    parameter int SECT_SHIFT = 12,
    parameter int ERASE_WAIT = 100000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              done,
    input logic              f_we,
    input logic              f_rd,
    input logic [ADDR_W-1:0] f_addr,
    input logic [15:0]       f_wdata
);

    localparam int GW = $clog2(ERASE_WAIT + 3) + 1;

    logic          key2_q;
    logic          armed_q;
    logic [GW-1:0] gap_q;
    logic          confirm;

    assign confirm = f_we && (f_wdata == 16'h0030) && key2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key2_q  <= 1'b0;
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else begin
            key2_q <= f_we && (f_wdata == 16'h0055) && (f_addr == ADDR_W'(11'h2AA));
            if (confirm) begin
                armed_q <= 1'b1;
                gap_q   <= GW'(1);
            end else begin
                if (f_rd) armed_q <= 1'b0;
                if (gap_q != {GW{1'b1}}) gap_q <= gap_q + GW'(1);
            end
        end
    end

    assert_ack_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_sect_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        confirm |-> (f_addr[SECT_SHIFT-1:0] == '0));

    assert_erase_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_rd && armed_q) |-> (gap_q == GW'(ERASE_WAIT + 1)));

    assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_we && f_rd));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_accept_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ack);

endmodule

bind nfc_engine nfc_engine_chk #(
    .ADDR_W     (ADDR_W),
    .SECT_SHIFT (SECT_SHIFT),
    .ERASE_WAIT (ERASE_WAIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .done    (done),
    .f_we    (f_we),
    .f_rd    (f_rd),
    .f_addr  (f_addr),
    .f_wdata (f_wdata)
);

// File: tb/sim_nfc_engine.sv
module sim_nfc_engine;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int SECT_SHIFT = 12;
    localparam int SN_W       = ADDR_W - SECT_SHIFT;
    localparam int NS         = 1 << SN_W;
    localparam int EW         = 20;
    localparam int PP         = 6;
    localparam int EP         = 5;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic op = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic signed [SN_W:0] first_sect = '0;
    logic [SN_W-1:0] last_sect = '0;
    logic [NS-1:0] wp_map = '0;
    logic ack, done, f_we, f_rd;
    logic [1:0] status;
    logic [SN_W:0] skip_cnt;
    logic [ADDR_W-1:0] f_addr;
    logic [15:0] f_wdata;
    logic [15:0] f_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nfc_engine #(
        .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .ERASE_WAIT(EW),
        .PROG_POLLS(PP), .ERASE_POLLS(EP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .op(op), .addr(addr),
        .wdata(wdata), .first_sect(first_sect), .last_sect(last_sect),
        .wp_map(wp_map), .done(done), .status(status), .skip_cnt(skip_cnt),
        .f_addr(f_addr), .f_wdata(f_wdata), .f_we(f_we), .f_rd(f_rd),
        .f_rdata(f_rdata)
    );

    // flash model
    int lat_prog = 0;
    int lat_erase [NS];
    int busy = 0;
    int cyc = 0;
    int cfm_cyc = 0;
    int gap_err = 0;
    int rd_n = 0;
    int lg_n = 0;
    bit armed_prog = 0;
    bit erase_mode = 0;
    bit gap_pend = 0;
    logic [15:0] prog_val = '0;
    logic [15:0] lg_a [256];
    logic [15:0] lg_d [256];

    always @(posedge clk) begin
        cyc++;
        if (f_we) begin
            if (lg_n < 256) begin
                lg_a[lg_n] = f_addr;
                lg_d[lg_n] = f_wdata;
            end
            lg_n++;
            if (armed_prog) begin
                armed_prog = 0;
                busy = lat_prog;
                prog_val = f_wdata;
                erase_mode = 0;
            end else if (f_wdata == 16'h00A0 && f_addr == 16'h0555) begin
                armed_prog = 1;
            end else if (f_wdata == 16'h0030) begin
                busy = lat_erase[f_addr[15:12]];
                erase_mode = 1;
                cfm_cyc = cyc;
                gap_pend = 1;
            end
        end
        if (f_rd) begin
            rd_n++;
            if (gap_pend) begin
                if (cyc - cfm_cyc != EW + 1) gap_err++;
                gap_pend = 0;
            end
            if (busy > 0) begin
                busy--;
                f_rdata <= erase_mode ? 16'h0000 : (prog_val ^ 16'h0080);
            end else begin
                f_rdata <= erase_mode ? 16'hFFFF : prog_val;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected behaviour
    logic [15:0] ex_a [256];
    logic [15:0] ex_d [256];
    int ex_n, ex_sts, ex_skip;

    task automatic push_ex(input logic [15:0] a, input logic [15:0] d);
        ex_a[ex_n] = a;
        ex_d[ex_n] = d;
        ex_n++;
    endtask

    task automatic build_prog(input logic [15:0] a, input logic [15:0] d);
        ex_n = 0; ex_skip = 0;
        if (wp_map[a[15:12]]) begin
            ex_sts = 3;
        end else begin
            push_ex(16'h0555, 16'h00AA);
            push_ex(16'h02AA, 16'h0055);
            push_ex(16'h0555, 16'h00A0);
            push_ex(a, d);
            if (lat_prog >= PP) begin
                push_ex(a, 16'h00F0);
                ex_sts = 1;
            end else begin
                ex_sts = 0;
            end
        end
    endtask

    task automatic build_erase(input int f, input int l);
        ex_n = 0; ex_skip = 0; ex_sts = 0;
        if (f < 0 || f > l) begin
            ex_sts = 2;
        end else begin
            for (int s = f; s <= l; s++) begin
                logic [15:0] base;
                if (wp_map[s]) begin
                    ex_skip++;
                    continue;
                end
                base = 16'(s << SECT_SHIFT);
                push_ex(16'h0555, 16'h00AA);
                push_ex(16'h02AA, 16'h0055);
                push_ex(16'h0555, 16'h0080);
                push_ex(16'h0555, 16'h00AA);
                push_ex(16'h02AA, 16'h0055);
                push_ex(base, 16'h0030);
                push_ex(base, 16'h00F0);
                if (lat_erase[s] >= EP) begin
                    ex_sts = 1;
                    break;
                end
            end
        end
    endtask

    task automatic run_op(input logic o, input logic [15:0] a, input logic [15:0] d,
                          input int f, input int l);
        int hold, mism, got_sts, got_skip;
        string t_sts, t_seq;
        if (o) build_erase(f, l);
        else   build_prog(a, d);
        if (!o) t_sts = (ex_sts == 0) ? "R3" : (ex_sts == 1) ? "R4" : "R5";
        else    t_sts = (ex_sts == 0) ? "R7" : (ex_sts == 1) ? "R11" : "R9";
        t_seq = o ? "R6 R8 erase cycles" : "R2 program cycles";
        @(negedge clk);
        op = o; addr = a; wdata = d;
        first_sect = f[SN_W:0]; last_sect = l[SN_W-1:0];
        req = 1'b1;
        lg_n = 0; rd_n = 0; gap_err = 0;
        #1;
        chk("R1 ack while idle", int'(ack), 1);
        @(negedge clk);
        addr = ~a; wdata = ~d; first_sect = '0; last_sect = '1; op = ~o;
        hold = 0;
        while (!done) begin
            if (ack) hold++;
            @(negedge clk);
        end
        got_sts = int'(status);
        got_skip = int'(skip_cnt);
        req = 1'b0;
        chk("R1 hold-off", hold, 0);
        chk(t_sts, got_sts, ex_sts);
        chk("R10 skip count", got_skip, ex_skip);
        chk(t_seq, lg_n, ex_n);
        mism = 0;
        for (int i = 0; i < ex_n && i < lg_n && i < 256; i++)
            if (lg_a[i] !== ex_a[i] || lg_d[i] !== ex_d[i]) mism++;
        chk(t_seq, mism, 0);
        if (ex_n == 0) chk(ex_sts == 2 ? "R9 no reads" : "R5 no reads", rd_n, 0);
        if (o) chk("R7 poll delay", gap_err, 0);
        @(negedge clk);
        chk("R12 done pulse", int'(done), 0);
    endtask

    task automatic set_lat_all(input int v);
        for (int s = 0; s < NS; s++) lat_erase[s] = v;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        set_lat_all(0);
        repeat (3) @(negedge clk);
        chk("R12 reset done", int'(done), 0);
        chk("R12 reset ack", int'(ack), 0);
        chk("R12 reset we", int'(f_we), 0);
        chk("R12 reset rd", int'(f_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle no req", int'(ack), 0);

        // program: fast, last permitted read, exhausted budget, protected
        lat_prog = 0;      run_op(1'b0, 16'h1234, 16'h5A80, 0, 0);
        lat_prog = PP - 1; run_op(1'b0, 16'h2001, 16'h0042, 0, 0);
        lat_prog = PP;     run_op(1'b0, 16'h3002, 16'h00C3, 0, 0);
        wp_map = 16'h0010;
        lat_prog = 0;      run_op(1'b0, 16'h4567, 16'h1111, 0, 0);
        wp_map = '0;
        lat_prog = 2;      run_op(1'b0, 16'h0555, 16'h0030, 0, 0);

        // erase: bad ranges, protected skip, coincidence, mid-range stop
        run_op(1'b1, 16'h0, 16'h0, -1, 3);
        run_op(1'b1, 16'h0, 16'h0, 5, 2);
        wp_map = 16'h0024;
        set_lat_all(1);
        run_op(1'b1, 16'h0, 16'h0, 1, 6);
        set_lat_all(EP - 1);
        run_op(1'b1, 16'h0, 16'h0, 15, 15);
        set_lat_all(0);
        lat_erase[4] = EP;
        run_op(1'b1, 16'h0, 16'h0, 3, 8);
        wp_map = '1;
        run_op(1'b1, 16'h0, 16'h0, 0, 15);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic o;
            int f, l;
            o = 1'($urandom);
            wp_map = NS'($urandom) & NS'($urandom);
            lat_prog = int'($urandom_range(0, PP + 1));
            for (int s = 0; s < NS; s++)
                lat_erase[s] = ($urandom_range(0, 7) == 0) ? EP : int'($urandom_range(0, EP - 1));
            f = int'($urandom_range(0, NS + 1)) - 2;
            l = int'($urandom_range(0, NS - 1));
            run_op(o, 16'($urandom), 16'($urandom), f, l);
        end

        finish_run();
    end

endmodule